// File: doc/BRIEF.md
# XON/XOFF Software Flow Controller

This block manages in-band (software) flow control for a serial link. On the receive side it watches how full the local receive FIFO is. When the FIFO gets too full it asks the UART transmitter to send an XOFF character so that the far end stops sending. Once the FIFO has drained, it asks for an XON character so that the far end resumes. Each received byte also passes through the block on its way to the FIFO. A byte that matches the programmed XOFF or XON code is taken out of the stream. It raises a one-cycle interrupt pulse and sets or clears a pause level that holds back the local transmitter.

The insert request is a level with a handshake. It stays high, with its character fixed, until the transmitter acknowledges it. The transmitter must send the control character before its next FIFO byte, at the next frame boundary. The block tracks whether it has already paused the far end. An XOFF is therefore sent only once per crossing of the upper threshold. An XON is sent only after an XOFF has been accepted. Together with separate upper and lower thresholds, this gives hysteresis. The local pause level changes only while the transmitter reports that no frame is in progress, so a frame that has already started always completes.

Top module: `xonxoff_flow_ctl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `ins_req`, `tx_pause`, `xon_irq` and `xoff_irq` are all 0.
- R2: With `enable` high, no request pending and the far end not yet paused, a `rx_level` strictly greater than `hi_thresh` raises `ins_req` after the next clock edge, with `ins_data` equal to `xoff_code`. A level equal to `hi_thresh` raises nothing.
- R3: Once raised, `ins_req` stays high and `ins_data` stays unchanged until a clock edge at which `ins_ack` is high. After that edge `ins_req` is low.
- R4: After an XOFF has been acknowledged, no further XOFF is requested while `rx_level` stays above `hi_thresh`.
- R5: After an acknowledged XOFF, an XON (`ins_data` equal to `xon_code`) is requested only when `rx_level` is strictly less than `lo_thresh`. A level between the thresholds requests nothing. After the XON is acknowledged, a later rise above `hi_thresh` requests XOFF again.
- R6: A byte accepted with `rx_valid` high that equals `xoff_code` (or `xon_code`) makes `xoff_irq` (or `xon_irq`) high for exactly the cycle after that edge.
- R7: With `enable` high, a received byte equal to either code is not forwarded (`fifo_wr` low in that cycle). Any other byte is forwarded in the same cycle (`fifo_wr` equals `rx_valid`).
- R8: With `enable` low, no request is raised and a pending request is dropped. No interrupt fires, every received byte is forwarded, and `tx_pause` is cleared.
- R9: A received XOFF sets `tx_pause` and a received XON clears it. `tx_pause` changes only at an edge where `tx_busy` is low. A pause that arrives while a frame is in progress takes effect at the first edge with `tx_busy` low.
- R10: When `xon_code` equals `xoff_code`, a matching byte is treated as XOFF only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Software flow control on |
| rx_level | input | CW | Current receive FIFO fill count |
| hi_thresh | input | CW | Level above which XOFF is requested |
| lo_thresh | input | CW | Level below which XON is requested |
| xon_code | input | 8 | Resume character |
| xoff_code | input | 8 | Pause character |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| fifo_wr | output | 1 | Write strobe toward the receive FIFO |
| tx_busy | input | 1 | Transmitter is mid-frame |
| ins_req | output | 1 | Control character insert request |
| ins_data | output | 8 | Character to insert |
| ins_ack | input | 1 | Transmitter takes the inserted character |
| tx_pause | output | 1 | Hold the local transmitter |
| xon_irq | output | 1 | XON received pulse |
| xoff_irq | output | 1 | XOFF received pulse |

## Verification
The assertions assume that `xon_code`, `xoff_code` and the thresholds stay constant while a request is outstanding. They also assume that `lo_thresh` does not exceed `hi_thresh`, and that `ins_ack` is driven only while `ins_req` is high. The bench changes codes and thresholds only while no request is pending and always keeps the lower threshold at or below the upper one. It raises `ins_ack` only after it has seen `ins_req`, and it holds `tx_busy` high across a received XOFF so that the deferred pause can be observed.

// File: rtl/xonxoff_flow_ctl.sv
module xonxoff_flow_ctl #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic [CW-1:0] rx_level,
  input  logic [CW-1:0] hi_thresh,
  input  logic [CW-1:0] lo_thresh,
  input  logic [7:0]    xon_code,
  input  logic [7:0]    xoff_code,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  output logic          fifo_wr,
  input  logic          tx_busy,
  output logic          ins_req,
  output logic [7:0]    ins_data,
  input  logic          ins_ack,
  output logic          tx_pause,
  output logic          xon_irq,
  output logic          xoff_irq
);

  logic remote_off;
  logic sent_xoff;
  logic pause_want;

  wire xoff_hit  = enable && rx_valid && (rx_data == xoff_code);
  wire xon_hit   = enable && rx_valid && (rx_data == xon_code) && !xoff_hit;
  wire want_xoff = !remote_off && (rx_level > hi_thresh);
  wire want_xon  = remote_off && (rx_level < lo_thresh);
  wire pause_nxt = xoff_hit ? 1'b1 : (xon_hit ? 1'b0 : pause_want);

  assign fifo_wr = rx_valid && !(xoff_hit || xon_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ins_req    <= 1'b0;
      ins_data   <= 8'h00;
      remote_off <= 1'b0;
      sent_xoff  <= 1'b0;
      pause_want <= 1'b0;
      tx_pause   <= 1'b0;
      xon_irq    <= 1'b0;
      xoff_irq   <= 1'b0;
    end else if (!enable) begin
      ins_req    <= 1'b0;
      remote_off <= 1'b0;
      pause_want <= 1'b0;
      tx_pause   <= 1'b0;
      xon_irq    <= 1'b0;
      xoff_irq   <= 1'b0;
    end else begin
      xon_irq    <= xon_hit;
      xoff_irq   <= xoff_hit;
      pause_want <= pause_nxt;
      if (!tx_busy) tx_pause <= pause_nxt;

      if (ins_req) begin
        if (ins_ack) begin
          ins_req    <= 1'b0;
          remote_off <= sent_xoff;
        end
      end else if (want_xoff) begin
        ins_req   <= 1'b1;
        ins_data  <= xoff_code;
        sent_xoff <= 1'b1;
      end else if (want_xon) begin
        ins_req   <= 1'b1;
        ins_data  <= xon_code;
        sent_xoff <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/xonxoff_flow_ctl_chk.sv
module xonxoff_flow_ctl_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          enable,
  input logic [CW-1:0] rx_level,
  input logic [CW-1:0] hi_thresh,
  input logic [CW-1:0] lo_thresh,
  input logic [7:0]    xon_code,
  input logic [7:0]    xoff_code,
  input logic          rx_valid,
  input logic [7:0]    rx_data,
  input logic          fifo_wr,
  input logic          tx_busy,
  input logic          ins_req,
  input logic [7:0]    ins_data,
  input logic          ins_ack,
  input logic          tx_pause,
  input logic          xon_irq,
  input logic          xoff_irq
);

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!ins_req && !tx_pause && !xon_irq && !xoff_irq));

  a_r2_code_valid: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ins_req) |-> (ins_data == xoff_code || ins_data == xon_code));

  a_r3_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_req && !ins_ack && enable) |=> (ins_req && $stable(ins_data)));

  a_r3_drop_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_req && ins_ack) |=> !ins_req);

  a_r6_xoff_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && rx_valid && rx_data == xoff_code) |=> xoff_irq);

  a_r6_one_hot_irq: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({xon_irq, xoff_irq}));

  a_r7_no_forward: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && rx_valid && (rx_data == xon_code || rx_data == xoff_code)) |-> !fifo_wr);

  a_r8_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!ins_req && !xon_irq && !xoff_irq && !tx_pause));

  a_r9_busy_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && enable) |=> $stable(tx_pause));

endmodule

bind xonxoff_flow_ctl xonxoff_flow_ctl_chk #(.CW(CW)) u_chk (.*);

// File: tb/xonxoff_flow_ctl_bench.sv
module xonxoff_flow_ctl_bench;
  localparam int CLK_P = 10;
  localparam int CW = 8;
  localparam int NROW = 8;
  // row: {data[7:0], exp_fifo_wr, exp_xon_irq, exp_xoff_irq}
  localparam logic [10:0] TBL [NROW] = '{
    {8'h41, 3'b100}, {8'h11, 3'b010}, {8'h13, 3'b001}, {8'h12, 3'b100},
    {8'h00, 3'b100}, {8'h13, 3'b001}, {8'hFF, 3'b100}, {8'h11, 3'b010}
  };

  logic clk = 0, rst_n = 0, enable = 0;
  logic [CW-1:0] rx_level = 0, hi_thresh = 10, lo_thresh = 4;
  logic [7:0] xon_code = 8'h11, xoff_code = 8'h13;
  logic rx_valid = 0, tx_busy = 0, ins_ack = 0;
  logic [7:0] rx_data = 0;
  logic fifo_wr, ins_req, tx_pause, xon_irq, xoff_irq;
  logic [7:0] ins_data;
  int n_chk = 0, n_bad = 0;
  bit model_pause;

  always #(CLK_P/2) clk = ~clk;

  xonxoff_flow_ctl #(.CW(CW)) u_xonxoff_flow_ctl (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic rx_byte(logic [7:0] d);
    rx_valid = 1; rx_data = d;
    step();
    rx_valid = 0;
  endtask

  initial begin
    #(CLK_P * 150000);
    n_bad++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    step(2);
    chk("R1 req in reset", ins_req, 0);
    chk("R1 pause in reset", tx_pause, 0);
    rst_n = 1; enable = 1; rx_level = 6;
    step();
    chk("R1 req after reset", ins_req, 0);
    chk("R1 irq after reset", {xon_irq, xoff_irq}, 0);

    model_pause = 0;
    for (int i = 0; i < NROW; i++) begin
      rx_valid = 1; rx_data = TBL[i][10:3];
      #1;
      chk("R7 forward", fifo_wr, TBL[i][2]);
      step();
      rx_valid = 0;
      if (TBL[i][0]) model_pause = 1;
      else if (TBL[i][1]) model_pause = 0;
      chk("R6 xon pulse", xon_irq, TBL[i][1]);
      chk("R6 xoff pulse", xoff_irq, TBL[i][0]);
      chk("R9 pause level", tx_pause, model_pause);
    end
    step();
    chk("R6 pulse ends", {xon_irq, xoff_irq}, 0);

    rx_level = 10; step(2);
    chk("R2 equal to hi", ins_req, 0);
    rx_level = 11; step();
    chk("R2 xoff req", ins_req, 1);
    chk("R2 xoff data", ins_data, 8'h13);
    step(3);
    chk("R3 held", ins_req, 1);
    chk("R3 data held", ins_data, 8'h13);
    ins_ack = 1; step(); ins_ack = 0;
    chk("R3 dropped on ack", ins_req, 0);
    step(3);
    chk("R4 no repeat xoff", ins_req, 0);
    rx_level = 6; step(2);
    chk("R5 between thresholds", ins_req, 0);
    rx_level = 4; step(2);
    chk("R5 equal to lo", ins_req, 0);
    rx_level = 3; step();
    chk("R5 xon req", ins_req, 1);
    chk("R5 xon data", ins_data, 8'h11);
    ins_ack = 1; step(); ins_ack = 0;
    step(2);
    chk("R5 no repeat xon", ins_req, 0);
    rx_level = 12; step();
    chk("R5 xoff again", ins_req, 1);
    chk("R5 xoff again data", ins_data, 8'h13);
    ins_ack = 1; step(); ins_ack = 0;

    tx_busy = 1;
    rx_byte(8'h13);
    chk("R9 pause deferred", tx_pause, 0);
    step(2);
    chk("R9 still deferred", tx_pause, 0);
    tx_busy = 0; step();
    chk("R9 pause applied", tx_pause, 1);
    rx_byte(8'h11);
    chk("R9 pause released", tx_pause, 0);

    xon_code = 8'h13;
    rx_byte(8'h13);
    chk("R10 xon suppressed", xon_irq, 0);
    chk("R10 xoff wins", xoff_irq, 1);
    chk("R10 pause set", tx_pause, 1);
    xon_code = 8'h11;

    rx_level = 2; step();
    chk("R8 pending req", ins_req, 1);
    enable = 0; step();
    chk("R8 req dropped", ins_req, 0);
    chk("R8 pause cleared", tx_pause, 0);
    rx_level = 40; step(2);
    chk("R8 no req", ins_req, 0);
    rx_valid = 1; rx_data = 8'h13; #1;
    chk("R8 code forwarded", fifo_wr, 1);
    step(); rx_valid = 0;
    chk("R8 no irq", {xon_irq, xoff_irq}, 0);

    rst_n = 0; step();
    chk("R1 reset again", {ins_req, tx_pause}, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule